// File: doc/BRIEF.md
# Differential Crossbar Write-Verify Sequencer

This block turns a stream of quantized synaptic weights into write pulses for a resistive crossbar in which every weight occupies two cells, one on a positive column and one on a negative column. A weight is accepted over a valid/ready handshake and decoded into a pair of target states, low resistance (active) or high resistance (inactive). The two cells are then programmed one after the other, positive column first. Each cell gets a staircase of pulses whose amplitude rises from a start value by a fixed step. After every pulse the external read path reports how far the cell still is from its target, and the staircase ends once that distance is within tolerance.

Active cells use a long staircase with small steps. Inactive cells use a short staircase with large steps, so the cells that draw little current cost little write time and energy. An optional mixed mode starts an active cell on the large steps and drops to the small steps once the read distance enters a configurable window. If a cell uses up its pulse allowance without passing, its location is reported as a fault and the sequence moves on. Two counters total the pulses issued under each step scheme, and a one-cycle done strobe marks the end of each full pass over the array.

Top module: `xbar_prog_seq`

## Requirements
- R1: In ternary mode (`bin_mode`=0), `w_code` 2'b01 means +1: positive cell active, negative cell inactive. 2'b11 means -1, which is the mirror image. 2'b00 and 2'b10 mean 0, with both cells inactive. `pulse_set` is 1 exactly when the cell being pulsed has an active target.
- R2: In binary mode (`bin_mode`=1) only `w_code[1]` is used. 0 selects +1 and 1 selects -1.
- R3: `w_ready` is high only while the block is idle. An accepted weight at address A programs cell (A, `pulse_col`=0) and then cell (A, `pulse_col`=1). The first pulse appears on the cycle after acceptance. Successive weights take addresses 0, 1, ..., N_CELLS-1.
- R4: An active-target cell without mixed mode gets pulses at `cfg_fine_start`, then rising by `cfg_fine_step` each time, up to FINE_PULSES (30) pulses.
- R5: An inactive-target cell gets pulses at `cfg_coarse_start`, then rising by `cfg_coarse_step` each time, up to COARSE_PULSES (3) pulses.
- R6: Each pulse is one cycle wide and is followed by a wait for `rd_valid`. The read passes when `rd_err` is at most `cfg_tol_lrs` (active target) or `cfg_tol_hrs` (inactive target). After a failing read the next pulse comes on the following cycle, and after a passing read the cell's staircase ends. `rd_valid` has no effect while the block is idle.
- R7: The pulse amplitude saturates at its all-ones maximum and never wraps.
- R8: With `hyb_en`=1, an active-target cell starts at `cfg_coarse_start` with coarse steps. After a failing read with `rd_err` at most `cfg_near_win`, the following steps use `cfg_fine_step`. The allowance stays at FINE_PULSES.
- R9: A failing read on the last allowed pulse raises `fault_valid` for one cycle, with `fault_addr`/`fault_col` naming the cell. The sequence then continues with the next cell.
- R10: `done` is high for one cycle, together with `w_ready`, after the negative cell of address N_CELLS-1 finishes. Addressing then wraps to 0.
- R11: Each pulse increments `cnt_coarse` if it was issued under coarse stepping and `cnt_fine` otherwise. The counters are visible on the cycle after the pulse.
- R12: After reset: `w_ready`=1, `pulse_valid`=0, `fault_valid`=0, `done`=0, both counters 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bin_mode | input | 1 | binary weight decode |
| hyb_en | input | 1 | mixed coarse-then-fine staircase for active cells |
| cfg_fine_start | input | AMP_W | first amplitude, fine staircase |
| cfg_fine_step | input | AMP_W | fine amplitude increment |
| cfg_coarse_start | input | AMP_W | first amplitude, coarse staircase |
| cfg_coarse_step | input | AMP_W | coarse amplitude increment |
| cfg_tol_lrs | input | ERR_W | pass tolerance, active target |
| cfg_tol_hrs | input | ERR_W | pass tolerance, inactive target |
| cfg_near_win | input | ERR_W | distance that switches mixed mode to fine steps |
| w_valid | input | 1 | weight offered |
| w_code | input | 2 | weight code |
| w_ready | output | 1 | weight accepted when high with w_valid |
| pulse_valid | output | 1 | write pulse strobe |
| pulse_addr | output | ADDR_W | weight address of the pulsed cell |
| pulse_col | output | 1 | 0 positive column, 1 negative column |
| pulse_set | output | 1 | 1 drive toward low resistance |
| pulse_amp | output | AMP_W | pulse amplitude code |
| rd_valid | input | 1 | verify read result present |
| rd_err | input | ERR_W | distance of cell from its target |
| fault_valid | output | 1 | cell gave up |
| fault_addr | output | ADDR_W | address of failed cell |
| fault_col | output | 1 | column of failed cell |
| done | output | 1 | end of array pass |
| cnt_fine | output | CNT_W | pulses issued under fine stepping |
| cnt_coarse | output | CNT_W | pulses issued under coarse stepping |

## Verification
The bench plays the cell itself. Each cell has a threshold amplitude, and the bench returns the shortfall as the read distance, so every staircase length follows from arithmetic rather than scripted answers. The corner cases it targets are:
- Stuck cells that exhaust both allowances. A design with an off-by-one budget would emit 29 or 31 pulses, or put the fault on the wrong cell.
- A large coarse step that would overflow the amplitude. A non-saturating adder would wrap to a small pulse.
- The mixed-mode switch point. A design that switched early, late, or on the passing read would produce a different amplitude trail and a different split between the two counters.
- Binary decoding of 2'b10 and 2'b00, the wrap of the address after the last cell, and read strobes while idle, which must not start anything.

// File: rtl/xbar_prog_pkg.sv
package xbar_prog_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT} seq_state_e;

  // one bit per column: 1 = low-resistance (active) target
  typedef struct packed {
    logic pos_act;
    logic neg_act;
  } cell_pair_t;

  function automatic cell_pair_t decode_weight(input logic [1:0] code, input logic binary);
    cell_pair_t p;
    if (binary) begin
      p.pos_act = ~code[1];
      p.neg_act = code[1];
    end else begin
      p.pos_act = (code == 2'b01);
      p.neg_act = (code == 2'b11);
    end
    return p;
  endfunction

endpackage

// File: rtl/xbar_weight_map.sv
module xbar_weight_map
  import xbar_prog_pkg::*;
(
  input  logic [1:0] code,
  input  logic       binary,
  output cell_pair_t pair
);
  always_comb pair = decode_weight(code, binary);
endmodule

// File: rtl/xbar_ramp.sv
module xbar_ramp #(
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hyb_en,
  input  logic             load,
  input  logic             load_act,
  input  logic             adv,
  input  logic             adv_act,
  input  logic             near,
  input  logic [AMP_W-1:0] fine_start,
  input  logic [AMP_W-1:0] fine_step,
  input  logic [AMP_W-1:0] coarse_start,
  input  logic [AMP_W-1:0] coarse_step,
  output logic [AMP_W-1:0] amp,
  output logic             coarse_mode
);

  function automatic logic [AMP_W-1:0] sat_add(input logic [AMP_W-1:0] a, input logic [AMP_W-1:0] b);
    logic [AMP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[AMP_W] ? {AMP_W{1'b1}} : s[AMP_W-1:0];
  endfunction

  logic load_coarse, next_coarse;
  assign load_coarse = ~load_act | hyb_en;
  assign next_coarse = coarse_mode & ~(adv_act & near);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp         <= '0;
      coarse_mode <= 1'b0;
    end else if (load) begin
      coarse_mode <= load_coarse;
      amp         <= load_coarse ? coarse_start : fine_start;
    end else if (adv) begin
      coarse_mode <= next_coarse;
      amp         <= sat_add(amp, next_coarse ? coarse_step : fine_step);
    end
  end

  // R7
  amp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> amp >= $past(amp));

endmodule

// File: rtl/xbar_pulse_tally.sv
module xbar_pulse_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic             coarse,
  output logic [CNT_W-1:0] cnt_fine,
  output logic [CNT_W-1:0] cnt_coarse
);

  for (genvar g = 0; g < 2; g++) begin : g_sch
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (pulse && (coarse == 1'(g)))   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_fine   = g_sch[0].cnt_q;
  assign cnt_coarse = g_sch[1].cnt_q;

  logic [CNT_W:0] total;
  assign total = {1'b0, cnt_fine} + {1'b0, cnt_coarse};

  // R11
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total == $past(total) + (CNT_W+1)'($past(pulse)));

endmodule

// File: rtl/xbar_prog_seq.sv
module xbar_prog_seq
  import xbar_prog_pkg::*;
#(
  parameter int N_CELLS       = 4,
  parameter int AMP_W         = 8,
  parameter int ERR_W         = 8,
  parameter int CNT_W         = 16,
  parameter int FINE_PULSES   = 30,
  parameter int COARSE_PULSES = 3,
  localparam int ADDR_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bin_mode,
  input  logic              hyb_en,
  input  logic [AMP_W-1:0]  cfg_fine_start,
  input  logic [AMP_W-1:0]  cfg_fine_step,
  input  logic [AMP_W-1:0]  cfg_coarse_start,
  input  logic [AMP_W-1:0]  cfg_coarse_step,
  input  logic [ERR_W-1:0]  cfg_tol_lrs,
  input  logic [ERR_W-1:0]  cfg_tol_hrs,
  input  logic [ERR_W-1:0]  cfg_near_win,
  input  logic              w_valid,
  input  logic [1:0]        w_code,
  output logic              w_ready,
  output logic              pulse_valid,
  output logic [ADDR_W-1:0] pulse_addr,
  output logic              pulse_col,
  output logic              pulse_set,
  output logic [AMP_W-1:0]  pulse_amp,
  input  logic              rd_valid,
  input  logic [ERR_W-1:0]  rd_err,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_col,
  output logic              done,
  output logic [CNT_W-1:0]  cnt_fine,
  output logic [CNT_W-1:0]  cnt_coarse
);

  localparam int IDX_W = $clog2(FINE_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_CELLS - 1);

  seq_state_e        state;
  cell_pair_t        pair, new_pair;
  logic [ADDR_W-1:0] addr;
  logic              col;
  logic [IDX_W-1:0]  idx;
  logic              fault_q, done_q;
  logic [ADDR_W-1:0] fault_addr_q;
  logic              fault_col_q;

  // named events shared with the assertions
  logic             act_tgt, accept, rd_take, pass, give_up, retry, cell_end, near, coarse_mode;
  logic             ramp_load, ramp_load_act;
  logic [IDX_W-1:0] budget;
  logic [ERR_W-1:0] tol;

  xbar_weight_map u_map (.code(w_code), .binary(bin_mode), .pair(new_pair));

  assign act_tgt  = col ? pair.neg_act : pair.pos_act;
  assign budget   = act_tgt ? IDX_W'(FINE_PULSES) : IDX_W'(COARSE_PULSES);
  assign tol      = act_tgt ? cfg_tol_lrs : cfg_tol_hrs;
  assign accept   = (state == S_IDLE) && w_valid;
  assign rd_take  = (state == S_WAIT) && rd_valid;
  assign pass     = rd_take && (rd_err <= tol);
  assign give_up  = rd_take && !pass && (idx == budget);
  assign retry    = rd_take && !pass && (idx != budget);
  assign cell_end = pass || give_up;
  assign near     = rd_err <= cfg_near_win;
  assign ramp_load     = accept || (cell_end && !col);
  assign ramp_load_act = accept ? new_pair.pos_act : pair.neg_act;

  xbar_ramp #(.AMP_W(AMP_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .hyb_en(hyb_en),
    .load(ramp_load), .load_act(ramp_load_act),
    .adv(retry), .adv_act(act_tgt), .near(near),
    .fine_start(cfg_fine_start), .fine_step(cfg_fine_step),
    .coarse_start(cfg_coarse_start), .coarse_step(cfg_coarse_step),
    .amp(pulse_amp), .coarse_mode(coarse_mode));

  xbar_pulse_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .pulse(pulse_valid), .coarse(coarse_mode),
    .cnt_fine(cnt_fine), .cnt_coarse(cnt_coarse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      pair         <= '0;
      addr         <= '0;
      col          <= 1'b0;
      idx          <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
      fault_col_q  <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          pair  <= new_pair;
          col   <= 1'b0;
          idx   <= '0;
          state <= S_PULSE;
        end
        S_PULSE: begin
          idx   <= idx + 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: if (rd_take) begin
          if (give_up) begin
            fault_q      <= 1'b1;
            fault_addr_q <= addr;
            fault_col_q  <= col;
          end
          if (retry) begin
            state <= S_PULSE;
          end else if (!col) begin
            col   <= 1'b1;
            idx   <= '0;
            state <= S_PULSE;
          end else begin
            state <= S_IDLE;
            if (addr == LAST_ADDR) begin
              addr   <= '0;
              done_q <= 1'b1;
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign w_ready     = (state == S_IDLE);
  assign pulse_valid = (state == S_PULSE);
  assign pulse_addr  = addr;
  assign pulse_col   = col;
  assign pulse_set   = act_tgt;
  assign fault_valid = fault_q;
  assign fault_addr  = fault_addr_q;
  assign fault_col   = fault_col_q;
  assign done        = done_q;

  // R6
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid |=> !pulse_valid);

  // R4
  fine_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_valid && pulse_set) |-> idx < IDX_W'(FINE_PULSES));

  // R5
  coarse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_valid && !pulse_set) |-> idx < IDX_W'(COARSE_PULSES));

  // R9
  fault_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(rd_valid) && !pulse_set == !pulse_set);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (w_ready && $past(col)));

  // R3
  ready_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_valid) |-> ($past(w_valid) || $past(rd_valid)));

endmodule

// File: tb/tb_xbar_prog_seq.sv
module tb_xbar_prog_seq;

  localparam int NC = 4;

  logic       clk = 0, rst_n = 0;
  logic       bin_mode = 0, hyb_en = 0;
  logic [7:0] cfg_fine_start = 10, cfg_fine_step = 2;
  logic [7:0] cfg_coarse_start = 40, cfg_coarse_step = 50;
  logic [7:0] cfg_tol_lrs = 1, cfg_tol_hrs = 5, cfg_near_win = 20;
  logic       w_valid = 0;
  logic [1:0] w_code = 0;
  logic       w_ready, pulse_valid, pulse_col, pulse_set;
  logic [1:0] pulse_addr, fault_addr;
  logic [7:0] pulse_amp;
  logic       rd_valid = 0;
  logic [7:0] rd_err = 0;
  logic       fault_valid, fault_col, done;
  logic [15:0] cnt_fine, cnt_coarse;

  xbar_prog_seq dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_fine = 0, exp_coarse = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // R11: per-clock comparison of the pulse tallies
  always @(negedge clk) if (mon_on) begin
    chk(cnt_fine == 16'(exp_fine), "R11 fine tally", cnt_fine, exp_fine);
    chk(cnt_coarse == 16'(exp_coarse), "R11 coarse tally", cnt_coarse, exp_coarse);
  end

  // reference cell: remaining shortfall of amplitude against threshold, capped
  function automatic int shortfall(input int thr, input int a);
    int e = thr - a;
    if (e < 0) e = 0;
    if (e > 255) e = 255;
    return e;
  endfunction

  // runs at a negedge where the first pulse of the cell must be visible
  task automatic run_cell(input int addr, input int col, input bit act, input int thr,
                          input bit last_cell, input string mtag);
    bit coarse = !act || hyb_en;
    int a = coarse ? int'(cfg_coarse_start) : int'(cfg_fine_start);
    int budget = act ? 30 : 3;
    int tol = act ? int'(cfg_tol_lrs) : int'(cfg_tol_hrs);
    for (int n = 1; n <= budget; n++) begin
      int e;
      bit ok_rd, stop;
      string atag;
      atag = (a == 255) ? "R7 saturated amp" : (!act ? "R5 coarse amp" : (hyb_en ? "R8 mixed amp" : "R4 fine amp"));
      chk(pulse_valid == 1, "R6 pulse timing", pulse_valid, 1);
      chk(pulse_amp == 8'(a), atag, pulse_amp, a);
      chk(pulse_set == act, mtag, pulse_set, act);
      chk(pulse_col == col[0] && pulse_addr == 2'(addr), "R3 cell order", {pulse_addr, pulse_col}, addr*2+col);
      chk(w_ready == 0, "R3 busy", w_ready, 0);
      @(posedge clk);
      if (coarse) exp_coarse++; else exp_fine++;
      @(negedge clk);
      chk(pulse_valid == 0, "R6 single-cycle pulse", pulse_valid, 0);
      e = shortfall(thr, a);
      rd_valid = 1; rd_err = 8'(e);
      @(posedge clk);
      @(negedge clk);
      rd_valid = 0;
      ok_rd = (e <= tol);
      stop  = ok_rd || (n == budget);
      chk(fault_valid == (!ok_rd && n == budget), "R9 fault strobe", fault_valid, !ok_rd && n == budget);
      if (fault_valid) begin
        chk(fault_addr == 2'(addr) && fault_col == col[0], "R9 fault location",
            {fault_addr, fault_col}, addr*2+col);
      end
      chk(done == (stop && last_cell && addr == NC-1), "R10 done strobe", done, stop && last_cell && addr == NC-1);
      if (stop) break;
      if (act && coarse && e <= int'(cfg_near_win)) coarse = 0;
      a = a + (coarse ? int'(cfg_coarse_step) : int'(cfg_fine_step));
      if (a > 255) a = 255;
    end
  endtask

  task automatic prog_weight(input logic [1:0] code, input bit bin, input int addr,
                             input int thr_p, input int thr_n);
    bit pa, na;
    string mtag;
    if (bin) begin pa = !code[1]; na = code[1]; mtag = "R2 binary decode"; end
    else begin pa = (code == 2'b01); na = (code == 2'b11); mtag = "R1 ternary decode"; end
    chk(w_ready == 1, "R3 ready when idle", w_ready, 1);
    bin_mode = bin; w_code = code; w_valid = 1;
    @(posedge clk);
    @(negedge clk);
    w_valid = 0;
    run_cell(addr, 0, pa, thr_p, 0, mtag);
    run_cell(addr, 1, na, thr_n, 1, mtag);
    chk(w_ready == 1, "R3 ready after weight", w_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12
    chk(w_ready == 1, "R12 reset ready", w_ready, 1);
    chk(pulse_valid == 0, "R12 reset pulse", pulse_valid, 0);
    chk(fault_valid == 0 && done == 0, "R12 reset strobes", {fault_valid, done}, 0);
    chk(cnt_fine == 0 && cnt_coarse == 0, "R12 reset tallies", cnt_fine + cnt_coarse, 0);
    mon_on = 1;

    prog_weight(2'b01, 0, 0, 20, 100);    // +1, fine ramp 6 pulses, coarse 3
    prog_weight(2'b11, 0, 1, 40, 15);     // -1
    prog_weight(2'b00, 0, 2, 40, 90);     // 0
    prog_weight(2'b10, 0, 3, 30, 30);     // 0 via spare code, done

    // R6: reads while idle do nothing
    for (int k = 0; k < 3; k++) begin
      rd_valid = 1; rd_err = 0;
      @(negedge clk);
      chk(pulse_valid == 0 && w_ready == 1, "R6 idle read ignored", pulse_valid, 0);
    end
    rd_valid = 0;

    prog_weight(2'b10, 1, 0, 40, 12);     // binary -1, address wrapped
    prog_weight(2'b00, 1, 1, 14, 40);     // binary +1
    prog_weight(2'b01, 0, 2, 1000, 1000); // both stuck: 30 and 3 pulses, faults
    hyb_en = 1;
    prog_weight(2'b01, 0, 3, 100, 100);   // mixed staircase, done
    hyb_en = 0;
    cfg_coarse_step = 150;
    prog_weight(2'b00, 0, 0, 1000, 1000); // saturation at 255, faults

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule